// File: doc/BRIEF.md
# H-Bridge Gate Sequencer with Dead Time

This block drives the four gate enables of one full bridge. These are the upper and lower switch of leg A and the upper and lower switch of leg B. It takes four commands:

- a direction select
- an active-low enable
- a PWM drive-on level
- a fast-decay flag

From them it decides which switches should conduct. It then times every change so that the two switches of one leg never conduct together.

A gate that has to open does so on the next clock edge. A gate that has to close waits for a programmable number of cycles first. If its partner on the same leg is still closed, the wait begins only once that partner has opened.

During the chopping off-time, the decay flag picks which switches open. In slow decay only the conducting upper switch opens. In fast decay both conducting switches open.

Top module: `bridge_gate_ctrl`

## Requirements
- R1: While rst_n is low, all four gate outputs are 0.
- R2: With phaseSel=1, enableN=0 and driveOn=1, the settled outputs are gateHiA=1 and gateLoB=1, with the other two at 0 (current from leg A to leg B).
- R3: With phaseSel=0, enableN=0 and driveOn=1, the settled outputs are gateHiB=1 and gateLoA=1, with the other two at 0 (reverse direction).
- R4: With enableN=1, all four gates are 0 after the next rising edge, whatever the other commands are.
- R5: With enableN=0, driveOn=0 and fastDecay=0 (slow decay), only the lower switch of the active direction stays on; both upper gates are 0.
- R6: With enableN=0, driveOn=0 and fastDecay=1 (fast decay), all four gates are 0.
- R7: A gate that is on and no longer required is 0 after the first rising edge that sees the new commands.
- R8: A gate that becomes required while its same-leg partner is off goes to 1 at the (deadCount+1)-th rising edge that sees the requirement.
- R9: A gate that becomes required while its same-leg partner is on goes to 1 at the (deadCount+2)-th rising edge. The partner opens at the first edge.
- R10: gateHiA and gateLoA are never 1 together, and gateHiB and gateLoB are never 1 together.
- R11: A requirement that lasts fewer than deadCount+1 rising edges never turns the gate on.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| phaseSel | input | 1 | Direction: 1 drives A to B, 0 drives B to A |
| enableN | input | 1 | Active-low bridge enable |
| driveOn | input | 1 | PWM level: 1 conducting, 0 chopping off-time |
| fastDecay | input | 1 | Off-time decay: 1 fast, 0 slow |
| deadCount | input | DEAD_W | Dead-time wait in cycles before a turn-on |
| gateHiA | output | 1 | Upper switch of leg A |
| gateLoA | output | 1 | Lower switch of leg A |
| gateHiB | output | 1 | Upper switch of leg B |
| gateLoB | output | 1 | Lower switch of leg B |

## Verification
The bench builds the block with DEAD_W=2, so every dead-time value from 0 to 3 is reachable. For each value it steps through every ordered pair of the 16 command combinations. That sweep covers each:

- direction reversal
- decay change
- enable toggle
- chop edge

Each gate's expected edge is derived from whether it opens, closes fresh, or closes behind a partner. A separate short-pulse case at the largest dead time shows that a brief requirement never turns a gate on.

// File: rtl/bridge_gate_pkg.sv
package bridge_gate_pkg;
  localparam int GATES  = 4;
  localparam int HI_A   = 0;
  localparam int LO_A   = 1;
  localparam int HI_B   = 2;
  localparam int LO_B   = 3;

  // Strobes from the command decoder to the timing datapath
  typedef struct packed {
    logic             killAll;
    logic [GATES-1:0] wantOn;
  } gateCmd_t;
endpackage

// File: rtl/bridge_cmd_decode.sv
module bridge_cmd_decode
  import bridge_gate_pkg::*;
(
  input  logic     phaseSel,
  input  logic     enableN,
  input  logic     driveOn,
  input  logic     fastDecay,
  output gateCmd_t cmd
);
  logic fwd;
  logic keepLow;

  assign fwd     = phaseSel;
  // Lower switch keeps conducting while driving, and during slow-decay chopping
  assign keepLow = driveOn | ~fastDecay;

  always_comb begin
    cmd.killAll      = enableN;
    cmd.wantOn[HI_A] = fwd & driveOn;
    cmd.wantOn[LO_B] = fwd & keepLow;
    cmd.wantOn[HI_B] = ~fwd & driveOn;
    cmd.wantOn[LO_A] = ~fwd & keepLow;
  end
endmodule

// File: rtl/bridge_dead_timer.sv
module bridge_dead_timer
  import bridge_gate_pkg::*;
#(
  parameter int DEAD_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  gateCmd_t          cmd,
  input  logic [DEAD_W-1:0] deadCount,
  output logic [GATES-1:0]  gateQ
);
  logic [GATES-1:0] wantEff;

  assign wantEff = cmd.wantOn & {GATES{~cmd.killAll}};

  for (genvar g = 0; g < GATES; g++) begin : g_gate
    localparam int PEER = g ^ 1;
    logic              gateOn;
    logic [DEAD_W-1:0] waitCnt;

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        gateOn  <= 1'b0;
        waitCnt <= '0;
      end else if (!wantEff[g]) begin
        gateOn  <= 1'b0;
        waitCnt <= '0;
      end else if (gateOn) begin
        gateOn  <= 1'b1;
      end else if (gateQ[PEER]) begin
        waitCnt <= '0;
      end else if (waitCnt >= deadCount) begin
        gateOn  <= 1'b1;
      end else begin
        waitCnt <= waitCnt + 1'b1;
      end
    end

    assign gateQ[g] = gateOn;

    p_off_next_r7: assert property (@(posedge clk) disable iff (!rst_n)
      !wantEff[g] |=> !gateQ[g]);

    p_on_needs_want_r8: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(gateQ[g]) |-> $past(wantEff[g]));

    p_peer_gap_r9: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(gateQ[g]) |-> !$past(gateQ[PEER]));
  end

  p_leg_excl_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !(gateQ[HI_A] && gateQ[LO_A]) && !(gateQ[HI_B] && gateQ[LO_B]));
endmodule

// File: rtl/bridge_gate_ctrl.sv
module bridge_gate_ctrl
  import bridge_gate_pkg::*;
#(
  parameter int DEAD_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              phaseSel,
  input  logic              enableN,
  input  logic              driveOn,
  input  logic              fastDecay,
  input  logic [DEAD_W-1:0] deadCount,
  output logic              gateHiA,
  output logic              gateLoA,
  output logic              gateHiB,
  output logic              gateLoB
);
  gateCmd_t         cmd;
  logic [GATES-1:0] gateQ;

  bridge_cmd_decode u_decode (
    .phaseSel  (phaseSel),
    .enableN   (enableN),
    .driveOn   (driveOn),
    .fastDecay (fastDecay),
    .cmd       (cmd)
  );

  bridge_dead_timer #(.DEAD_W(DEAD_W)) u_timer (
    .clk       (clk),
    .rst_n     (rst_n),
    .cmd       (cmd),
    .deadCount (deadCount),
    .gateQ     (gateQ)
  );

  assign gateHiA = gateQ[HI_A];
  assign gateLoA = gateQ[LO_A];
  assign gateHiB = gateQ[HI_B];
  assign gateLoB = gateQ[LO_B];

  p_disabled_off_r4: assert property (@(posedge clk) disable iff (!rst_n)
    enableN |=> !(gateHiA || gateLoA || gateHiB || gateLoB));

  p_slow_chop_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (!enableN && !driveOn && !fastDecay) |=> !(gateHiA || gateHiB));
endmodule

// File: tb/bridge_gate_ctrl_tb.sv
`timescale 1ns/1ps
module bridge_gate_ctrl_tb;
  localparam int DW = 2;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          phaseSel = 1'b0;
  logic          enableN = 1'b1;
  logic          driveOn = 1'b0;
  logic          fastDecay = 1'b0;
  logic [DW-1:0] deadCount = '0;
  logic          gateHiA, gateLoA, gateHiB, gateLoB;

  int total = 0;
  int bad   = 0;

  always #4 clk = ~clk;

  bridge_gate_ctrl #(.DEAD_W(DW)) u_dut (
    .clk(clk), .rst_n(rst_n), .phaseSel(phaseSel), .enableN(enableN),
    .driveOn(driveOn), .fastDecay(fastDecay), .deadCount(deadCount),
    .gateHiA(gateHiA), .gateLoA(gateLoA), .gateHiB(gateHiB), .gateLoB(gateLoB)
  );

  // bit0 hiA, bit1 loA, bit2 hiB, bit3 loB
  function automatic logic [3:0] gatesNow();
    return {gateLoB, gateHiB, gateLoA, gateHiA};
  endfunction

  // command code: bit0 phase, bit1 enableN, bit2 driveOn, bit3 fastDecay
  function automatic logic [3:0] wantOf(input logic [3:0] c);
    logic [3:0] w;
    w = 4'b0000;
    if (!c[1]) begin
      if (c[2]) w = c[0] ? 4'b1001 : 4'b0110;
      else if (!c[3]) w = c[0] ? 4'b1000 : 4'b0010;
    end
    return w;
  endfunction

  function automatic string steadyTag(input logic [3:0] c);
    if (c[1]) return "R4";
    if (c[2]) return c[0] ? "R2" : "R3";
    return c[3] ? "R6" : "R5";
  endfunction

  task automatic applyCmd(input logic [3:0] c);
    phaseSel  = c[0];
    enableN   = c[1];
    driveOn   = c[2];
    fastDecay = c[3];
  endtask

  task automatic check(input string tag, input logic [3:0] act, input logic [3:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%b expected=%b t=%0t", tag, act, exp, $time);
    end
  endtask

  task automatic checkLegs();
    logic [3:0] g;
    g = gatesNow();
    check("R10", {2'b00, g[2] & g[3], g[0] & g[1]}, 4'b0000);
  endtask

  initial begin
    int d;
    // R1: outputs held off during reset, even with a drive command present
    applyCmd(4'b0101);
    deadCount = '0;
    repeat (3) begin
      @(posedge clk); @(negedge clk);
      check("R1", gatesNow(), 4'b0000);
    end
    applyCmd(4'b0010);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    check("R4", gatesNow(), 4'b0000);

    for (d = 0; d < 4; d++) begin
      deadCount = DW'(d);
      for (int f = 0; f < 16; f++) begin
        for (int t = 0; t < 16; t++) begin
          logic [3:0] g0, w1;
          applyCmd(4'(f));
          repeat (d + 4) @(negedge clk);
          g0 = wantOf(4'(f));
          check(steadyTag(4'(f)), gatesNow(), g0);
          w1 = wantOf(4'(t));
          applyCmd(4'(t));
          for (int k = 1; k <= d + 3; k++) begin
            @(posedge clk); @(negedge clk);
            for (int i = 0; i < 4; i++) begin
              logic  e;
              string tag;
              if (!w1[i]) begin
                e = 1'b0;
                tag = "R7";
              end else if (g0[i]) begin
                e = 1'b1;
                tag = steadyTag(4'(t));
              end else if (g0[i ^ 1]) begin
                e = (k >= d + 2);
                tag = "R9";
              end else begin
                e = (k >= d + 1);
                tag = "R8";
              end
              check(tag, {3'b000, gatesNow()[i]}, {3'b000, e});
            end
            checkLegs();
          end
          check(steadyTag(4'(t)), gatesNow(), w1);
        end
      end
    end

    // R11: requirement held for only deadCount edges never turns the gate on
    deadCount = DW'(3);
    applyCmd(4'b0010);
    repeat (3) @(negedge clk);
    applyCmd(4'b0101);
    repeat (3) begin
      @(posedge clk); @(negedge clk);
      check("R11", gatesNow(), 4'b0000);
    end
    applyCmd(4'b0010);
    repeat (4) begin
      @(posedge clk); @(negedge clk);
      check("R11", gatesNow(), 4'b0000);
    end

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    bad++;
    total++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule